// File: doc/BRIEF.md
# Sector Write Data Sequencer

This block produces the complete byte stream for one sector write. The search logic finds the matching ID field and pulses `id_found`. The block then asks the host at once for the first data byte. It lets the first part of the ID-to-data gap go by with the write gate closed. If the host has supplied that byte by then, the block opens the gate. It then emits a run of zero bytes, the data address mark, the sector payload, a two-byte CRC and a closing 0xFF byte. Everything moves at the pace of a one-cycle `byte_tick` strobe that comes from the bit encoder.

The host side is a single holding register. A write on `host_wr` fills the register and drops `drq`. Each time the sequencer moves a byte into the output it raises `drq` again for the next byte. If the first request is missed, the sector is abandoned before anything is written. If a later request is missed, a zero byte is written in that slot, `lost_data` is flagged, and the write carries on.

The state machine has nine states:

- `ST_IDLE` waits for `id_found`.
- `ST_PREGAP` counts byte times with the gate closed.
- `ST_ZEROS` writes the zero preamble.
- `ST_MARK` writes the address mark.
- `ST_DATA` writes the payload.
- `ST_CRC_HI` and `ST_CRC_LO` write the check bytes.
- `ST_TRAIL` writes 0xFF.
- `ST_DRAIN` holds the gate for one more byte time and then finishes.

The transitions are:

- idle to pre-gap on `id_found`.
- pre-gap to idle (the abort path) when the first byte is missing at the end of the count.
- pre-gap to zeros when that byte is present.
- zeros to mark.
- mark to data.
- data to CRC-high after the last payload byte.
- CRC-high to CRC-low, CRC-low to trail, trail to drain.
- drain to idle.

Top module: `sector_writer`

## Requirements
- R1: After reset `wgate`, `drq`, `lost_data`, `done` and `wr_valid` are low. An `id_found` pulse in idle makes `drq` high and `lost_data` low in the next cycle.
- R2: After `id_found`, the block counts 11 `byte_tick` pulses (`dbl_density`=0) or 22 (`dbl_density`=1) with `wgate` low. The gate opens on the last of them.
- R3: If `drq` is still unserviced at the end of that count, `lost_data` is set and `done` pulses. `wgate` never rises, no byte is emitted, and `drq` drops.
- R4: Once the gate is open, the first 6 (single density) or 12 (double density) emitted bytes are 0x00.
- R5: The next emitted byte is the address mark, 0xF8 when `deleted_mark`=1 and 0xFB when it is 0. `wr_mark` is high with that byte only.
- R6: Payload bytes are the host's bytes in order. A `host_wr` drops `drq` in the next cycle. Taking a byte re-raises `drq` if more payload bytes remain.
- R7: A payload slot whose request was not serviced is written as 0x00 and sets `lost_data`. The remaining bytes still follow.
- R8: The payload length is 128 shifted left by `len_code` (0..3 gives 128, 256, 512, 1024). The code is latched at `id_found`.
- R9: Two CRC bytes follow the payload, high byte first. The CRC is x^16+x^12+x^5+1, MSB first, preset to 0xFFFF, and covers the mark and payload bytes as written.
- R10: A 0xFF byte follows the CRC. On the next `byte_tick`, `wgate` falls and `done` pulses for one cycle.
- R11: `wr_valid` pulses for one cycle only in the cycle after a `byte_tick`, once per emitted byte.
- R12: `id_found` has no effect while a write is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| byte_tick | input | 1 | One-cycle strobe per byte time from the encoder |
| id_found | input | 1 | Matching ID field found; starts a write |
| dbl_density | input | 1 | 1 = double density gap counts |
| deleted_mark | input | 1 | 1 = write the deleted-data mark |
| len_code | input | LEN_CODE_W | Payload length code |
| host_wr | input | 1 | Host loads the data register |
| host_byte | input | 8 | Byte written by the host |
| wgate | output | 1 | Write gate to the drive |
| wr_byte | output | 8 | Byte for the encoder |
| wr_valid | output | 1 | `wr_byte` is new this cycle |
| wr_mark | output | 1 | `wr_byte` is the address mark |
| drq | output | 1 | Data request to the host |
| lost_data | output | 1 | A request was missed during this write |
| done | output | 1 | One-cycle completion strobe |

## Verification
The assertions check several things on every cycle:

- `drq` rises after a start.
- `drq` drops after a host write.
- The gate stays closed during the pre-gap.
- The gate only falls together with `done`, right after 0xFF.
- Bytes appear only after a tick.
- The mark byte is one of the two legal values.
- A missed payload slot is zero-filled with `lost_data` set.

Other properties need whole scenarios from the bench, because they only show across a full sector. These are the exact pre-gap and preamble counts for each density, the payload order, the CRC value, the length decoding, the behaviour of an aborted write, and the ignoring of a second `id_found` mid-write.

// File: rtl/sw_pkg.sv
`timescale 1ns/1ps
package sw_pkg;
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PREGAP,
        ST_ZEROS,
        ST_MARK,
        ST_DATA,
        ST_CRC_HI,
        ST_CRC_LO,
        ST_TRAIL,
        ST_DRAIN
    } sw_state_e;

    localparam logic [7:0]  AM_NORMAL  = 8'hFB;
    localparam logic [7:0]  AM_DELETED = 8'hF8;
    localparam logic [7:0]  TRAIL_BYTE = 8'hFF;
    localparam logic [15:0] CRC_SEED   = 16'hFFFF;
    localparam logic [15:0] CRC_POLY   = 16'h1021;
endpackage

// File: rtl/sw_crc_step.sv
`timescale 1ns/1ps
// One byte of a MSB-first CRC, unrolled into a single combinational step.
module sw_crc_step #(
    parameter int          W    = 16,
    parameter logic [W-1:0] POLY = 16'h1021
) (
    input  logic [W-1:0] crc_in,
    input  logic [7:0]   din,
    output logic [W-1:0] crc_out
);
    logic [W-1:0] acc;

    always_comb begin
        acc = crc_in ^ {din, {(W-8){1'b0}}};
        for (int b = 0; b < 8; b++) begin
            if (acc[W-1]) acc = {acc[W-2:0], 1'b0} ^ POLY;
            else          acc = {acc[W-2:0], 1'b0};
        end
        crc_out = acc;
    end
endmodule

// File: rtl/sw_hold_reg.sv
`timescale 1ns/1ps
// Single-byte host holding register with its request flag.
module sw_hold_reg (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic       arm,
    input  logic       take,
    input  logic       host_wr,
    input  logic [7:0] host_byte,
    output logic       full,
    output logic [7:0] held_byte,
    output logic       drq
);
    logic full_d;
    logic drq_d;

    always_comb begin
        full_d = full;
        drq_d  = drq;
        if (clear) begin
            full_d = 1'b0;
            drq_d  = 1'b0;
        end
        if (take) begin
            full_d = 1'b0;
            drq_d  = 1'b0;
        end
        if (arm)     drq_d = 1'b1;
        if (host_wr) begin
            full_d = 1'b1;
            drq_d  = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full      <= 1'b0;
            drq       <= 1'b0;
            held_byte <= '0;
        end else begin
            full <= full_d;
            drq  <= drq_d;
            if (host_wr) held_byte <= host_byte;
        end
    end

    // R6: a host write satisfies the pending request and fills the register
    p_wr_clears_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
        host_wr |=> (!drq && full));
endmodule

// File: rtl/sector_writer.sv
`timescale 1ns/1ps
module sector_writer
    import sw_pkg::*;
#(
    parameter int SD_PREGAP  = 11,
    parameter int DD_PREGAP  = 22,
    parameter int SD_ZEROS   = 6,
    parameter int DD_ZEROS   = 12,
    parameter int BASE_LEN   = 128,
    parameter int LEN_CODE_W = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  byte_tick,
    input  logic                  id_found,
    input  logic                  dbl_density,
    input  logic                  deleted_mark,
    input  logic [LEN_CODE_W-1:0] len_code,
    input  logic                  host_wr,
    input  logic [7:0]            host_byte,
    output logic                  wgate,
    output logic [7:0]            wr_byte,
    output logic                  wr_valid,
    output logic                  wr_mark,
    output logic                  drq,
    output logic                  lost_data,
    output logic                  done
);
    localparam int MAX_LEN = BASE_LEN << ((1 << LEN_CODE_W) - 1);
    localparam int GAP_TOP = (DD_PREGAP > DD_ZEROS) ? DD_PREGAP : DD_ZEROS;
    localparam int CNT_W   = $clog2(MAX_LEN + GAP_TOP + 1);

    sw_state_e             state_q, state_d;
    logic [CNT_W-1:0]      cnt_q;
    logic [CNT_W-1:0]      lim;
    logic [CNT_W-1:0]      data_len;
    logic                  at_last;
    logic                  dd_q, del_q;
    logic [LEN_CODE_W-1:0] len_q;
    logic [15:0]           crc_q, crc_in, crc_nx;
    logic [7:0]            mark_byte;
    logic [7:0]            emit_byte;
    logic                  emit_en;
    logic                  start_go, abort_go, open_go, finish_go;
    logic                  buf_full;
    logic [7:0]            buf_byte;
    logic                  buf_clear, buf_arm, buf_take;

    // ---------------- limits and strobes ----------------
    assign data_len  = CNT_W'(BASE_LEN) << len_q;
    assign mark_byte = del_q ? AM_DELETED : AM_NORMAL;

    always_comb begin
        unique case (state_q)
            ST_PREGAP: lim = dd_q ? CNT_W'(DD_PREGAP - 1) : CNT_W'(SD_PREGAP - 1);
            ST_ZEROS:  lim = dd_q ? CNT_W'(DD_ZEROS - 1)  : CNT_W'(SD_ZEROS - 1);
            ST_DATA:   lim = data_len - 1'b1;
            default:   lim = '0;
        endcase
    end
    assign at_last = (cnt_q == lim);

    assign start_go  = id_found && (state_q == ST_IDLE);
    assign abort_go  = byte_tick && (state_q == ST_PREGAP) && at_last && !buf_full;
    assign open_go   = byte_tick && (state_q == ST_PREGAP) && at_last && buf_full;
    assign finish_go = byte_tick && (state_q == ST_DRAIN);

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (id_found) state_d = ST_PREGAP;
            ST_PREGAP: if (byte_tick && at_last) state_d = buf_full ? ST_ZEROS : ST_IDLE;
            ST_ZEROS:  if (byte_tick && at_last) state_d = ST_MARK;
            ST_MARK:   if (byte_tick) state_d = ST_DATA;
            ST_DATA:   if (byte_tick && at_last) state_d = ST_CRC_HI;
            ST_CRC_HI: if (byte_tick) state_d = ST_CRC_LO;
            ST_CRC_LO: if (byte_tick) state_d = ST_TRAIL;
            ST_TRAIL:  if (byte_tick) state_d = ST_DRAIN;
            ST_DRAIN:  if (byte_tick) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // ---------------- byte selection ----------------
    always_comb begin
        emit_en   = 1'b0;
        emit_byte = 8'h00;
        unique case (state_q)
            ST_ZEROS:  begin emit_en = byte_tick; emit_byte = 8'h00;        end
            ST_MARK:   begin emit_en = byte_tick; emit_byte = mark_byte;    end
            ST_DATA:   begin emit_en = byte_tick; emit_byte = buf_full ? buf_byte : 8'h00; end
            ST_CRC_HI: begin emit_en = byte_tick; emit_byte = crc_q[15:8];  end
            ST_CRC_LO: begin emit_en = byte_tick; emit_byte = crc_q[7:0];   end
            ST_TRAIL:  begin emit_en = byte_tick; emit_byte = TRAIL_BYTE;   end
            default:   begin emit_en = 1'b0;      emit_byte = 8'h00;        end
        endcase
    end

    assign crc_in = (state_q == ST_MARK) ? CRC_SEED : crc_q;

    sw_crc_step #(.W(16), .POLY(CRC_POLY)) u_crc (
        .crc_in (crc_in),
        .din    (emit_byte),
        .crc_out(crc_nx)
    );

    // ---------------- host holding register ----------------
    assign buf_clear = start_go || abort_go || finish_go;
    assign buf_arm   = start_go || (byte_tick && (state_q == ST_DATA) && !at_last);
    assign buf_take  = byte_tick && (state_q == ST_DATA) && buf_full;

    sw_hold_reg u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (buf_clear),
        .arm      (buf_arm),
        .take     (buf_take),
        .host_wr  (host_wr),
        .host_byte(host_byte),
        .full     (buf_full),
        .held_byte(buf_byte),
        .drq      (drq)
    );

    // ---------------- outputs and datapath ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            dd_q      <= 1'b0;
            del_q     <= 1'b0;
            len_q     <= '0;
            crc_q     <= CRC_SEED;
            wgate     <= 1'b0;
            wr_byte   <= 8'h00;
            wr_valid  <= 1'b0;
            wr_mark   <= 1'b0;
            lost_data <= 1'b0;
            done      <= 1'b0;
        end else begin
            wr_valid <= emit_en;
            wr_mark  <= emit_en && (state_q == ST_MARK);
            done     <= 1'b0;
            if (emit_en) wr_byte <= emit_byte;

            if (state_d != state_q)                     cnt_q <= '0;
            else if (byte_tick && state_q != ST_IDLE)   cnt_q <= cnt_q + 1'b1;

            if (start_go) begin
                dd_q      <= dbl_density;
                del_q     <= deleted_mark;
                len_q     <= len_code;
                lost_data <= 1'b0;
            end
            if (abort_go) begin
                lost_data <= 1'b1;
                done      <= 1'b1;
            end
            if (open_go) wgate <= 1'b1;

            if (byte_tick && state_q == ST_DATA && !buf_full) lost_data <= 1'b1;
            if (byte_tick && (state_q == ST_MARK || state_q == ST_DATA)) crc_q <= crc_nx;

            if (finish_go) begin
                wgate <= 1'b0;
                done  <= 1'b1;
            end
        end
    end

    // ---------------- assertions ----------------
    // R1: a start raises the first request and clears the loss flag
    p_first_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && id_found) |=> (drq && !lost_data && !wgate));

    // R2: the gate stays closed while the pre-gap is counted
    p_gate_closed_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PREGAP) |-> !wgate);

    // R3: an abort from the pre-gap reports lost data without opening the gate
    p_abort_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(done) && $past(state_q == ST_PREGAP)) |-> (lost_data && !wgate));

    // R5: the mark flag accompanies only a legal mark byte
    p_mark_byte_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_mark |-> (wr_valid && (wr_byte == AM_NORMAL || wr_byte == AM_DELETED)));

    // R7: an empty slot in the payload is filled with zero and flagged
    p_zero_fill_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && $past(state_q == ST_DATA) && $past(!buf_full)) |-> (wr_byte == 8'h00 && lost_data));

    // R10: the gate only closes with the done strobe, one byte after 0xFF
    p_gate_close_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wgate) |-> (done && wr_byte == TRAIL_BYTE));

    // R11: every byte follows a tick
    p_tick_paced_r11: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> $past(byte_tick));
endmodule

// File: tb/sector_writer_test.sv
`timescale 1ns/1ps
module sector_writer_test;
    localparam int NV  = 5;
    localparam int CAP = 1100;

    // vector table: density, deleted mark, length code, missed slot (-1 none, 0 first), mid-write restart
    localparam logic V_DD   [NV] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b1};
    localparam logic V_DEL  [NV] = '{1'b0, 1'b1, 1'b1, 1'b0, 1'b0};
    localparam int   V_CODE [NV] = '{0, 0, 1, 2, 3};
    localparam int   V_MISS [NV] = '{-1, 5, -1, 0, 1023};
    localparam logic V_POKE [NV] = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b0};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       byte_tick = 1'b0;
    logic       id_found = 1'b0;
    logic       dbl_density = 1'b0;
    logic       deleted_mark = 1'b0;
    logic [1:0] len_code = 2'd0;
    logic       host_wr = 1'b0;
    logic [7:0] host_byte = 8'h00;
    logic       wgate, wr_valid, wr_mark, drq, lost_data, done;
    logic [7:0] wr_byte;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    int div = 0;

    logic [7:0] cap [CAP];
    int  cnt_out, mark_idx, tick_err;
    int  cur_z, cur_n, cur_miss, cur_vec;
    bit  host_en, skipping, miss_used, done_seen, gate_seen, prev_tick;
    int  skip_at, host_delay, data_seen;

    always #2.5 clk = ~clk;

    sector_writer uut (
        .clk(clk), .rst_n(rst_n), .byte_tick(byte_tick), .id_found(id_found),
        .dbl_density(dbl_density), .deleted_mark(deleted_mark), .len_code(len_code),
        .host_wr(host_wr), .host_byte(host_byte), .wgate(wgate), .wr_byte(wr_byte),
        .wr_valid(wr_valid), .wr_mark(wr_mark), .drq(drq), .lost_data(lost_data), .done(done)
    );

    function automatic logic [7:0] pat(input int j, input int v);
        return 8'((j * 13) + (v * 29) + 1);
    endfunction

    function automatic logic [15:0] crc_bits(input logic [15:0] c, input logic [7:0] b);
        logic [15:0] r = c;
        for (int k = 7; k >= 0; k--) begin
            logic fb = r[15] ^ b[k];
            r = {r[14:0], 1'b0};
            if (fb) r = r ^ 16'h1021;
        end
        return r;
    endfunction

    task automatic check(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    // byte-time strobe, one cycle in eight, changed just after the rising edge
    always @(posedge clk) begin
        cyc++;
        #1;
        if (!rst_n) begin
            div = 0;
            byte_tick = 1'b0;
        end else begin
            byte_tick = (div == 7);
            div = (div + 1) % 8;
        end
    end

    // watchdog
    always @(posedge clk) begin
        if (cyc > 190000) begin
            fails++;
            $display("FAIL watchdog: got %0d expected below %0d", cyc, 190000);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    // output monitor followed by the host model
    always @(negedge clk) begin
        if (wr_valid) begin
            if (cnt_out < CAP) cap[cnt_out] = wr_byte;
            if (wr_mark) mark_idx = cnt_out;
            if (!prev_tick) tick_err++;
            cnt_out++;
        end
        if (done)  done_seen = 1'b1;
        if (wgate) gate_seen = 1'b1;
        prev_tick = byte_tick;

        host_wr = 1'b0;
        if (host_en) begin
            data_seen = (cnt_out > cur_z + 1) ? cnt_out - cur_z - 1 : 0;
            if (skipping && cnt_out > skip_at) skipping = 1'b0;
            if (!skipping && drq && data_seen < cur_n) begin
                if (data_seen == cur_miss && !miss_used) begin
                    skipping   = 1'b1;
                    miss_used  = 1'b1;
                    skip_at    = cnt_out;
                    host_delay = 0;
                end else begin
                    host_delay++;
                    if (host_delay >= 2) begin
                        host_wr    = 1'b1;
                        host_byte  = pat(data_seen, cur_vec);
                        host_delay = 0;
                    end
                end
            end else begin
                host_delay = 0;
            end
        end
    end

    task automatic run_vec(input int v);
        int p, ticks, mism, first_bad, exp_len;
        logic [15:0] crc;
        logic [7:0] expb;
        cur_vec    = v;
        cur_z      = V_DD[v] ? 12 : 6;
        p          = V_DD[v] ? 22 : 11;
        cur_n      = 128 << V_CODE[v];
        cur_miss   = V_MISS[v];
        cnt_out    = 0;
        mark_idx   = -1;
        skipping   = 1'b0;
        miss_used  = 1'b0;
        done_seen  = 1'b0;
        gate_seen  = 1'b0;
        host_delay = 0;

        @(negedge clk);
        dbl_density  = V_DD[v];
        deleted_mark = V_DEL[v];
        len_code     = 2'(V_CODE[v]);
        host_en      = 1'b1;
        id_found     = 1'b1;
        @(negedge clk);
        id_found     = 1'b0;
        dbl_density  = ~V_DD[v];
        len_code     = 2'(V_CODE[v] + 1);
        check("R1 drq after start", int'(drq), 1);
        check("R1 lost cleared at start", int'(lost_data), 0);

        ticks = 0;
        while (!(wgate || done_seen)) begin
            if (byte_tick) ticks++;
            @(negedge clk);
        end
        check("R2 pre-gap byte times", ticks, p);

        if (cur_miss == 0) begin
            repeat (20) @(negedge clk);
            check("R3 abort lost_data", int'(lost_data), 1);
            check("R3 abort gate never opened", int'(gate_seen), 0);
            check("R3 abort emits nothing", cnt_out, 0);
            check("R3 abort drops drq", int'(drq), 0);
            host_en = 1'b0;
            return;
        end

        if (V_POKE[v]) begin
            repeat (40) @(negedge clk);
            id_found = 1'b1;
            @(negedge clk);
            id_found = 1'b0;
        end

        while (!done_seen) @(negedge clk);
        repeat (3) @(negedge clk);
        host_en = 1'b0;

        exp_len = cur_z + 1 + cur_n + 3;
        if (V_POKE[v]) check("R12 restart ignored, stream length", cnt_out, exp_len);
        else           check("R8 stream length", cnt_out, exp_len);

        mism = 0;
        for (int j = 0; j < cur_z; j++) if (cap[j] != 8'h00) mism++;
        check("R4 zero preamble", mism, 0);

        expb = V_DEL[v] ? 8'hF8 : 8'hFB;
        check("R5 mark value", int'(cap[cur_z]), int'(expb));
        check("R5 mark flag position", mark_idx, cur_z);

        crc = crc_bits(16'hFFFF, expb);
        mism = 0;
        first_bad = -1;
        for (int j = 0; j < cur_n; j++) begin
            logic [7:0] e = (j == cur_miss) ? 8'h00 : pat(j, v);
            crc = crc_bits(crc, e);
            if (cap[cur_z + 1 + j] != e) begin
                mism++;
                if (first_bad < 0) first_bad = j;
            end
        end
        if (cur_miss > 0) check("R7 payload with zero-filled slot", mism, 0);
        else              check("R6 payload order", mism, 0);
        check("R7 lost_data flag", int'(lost_data), (cur_miss > 0) ? 1 : 0);

        check("R9 crc high byte", int'(cap[cur_z + 1 + cur_n]), int'(crc[15:8]));
        check("R9 crc low byte", int'(cap[cur_z + 2 + cur_n]), int'(crc[7:0]));
        check("R10 trailer 0xFF", int'(cap[cur_z + 3 + cur_n]), 8'hFF);
        check("R10 gate closed after done", int'(wgate), 0);
        check("R10 no request after done", int'(drq), 0);
    endtask

    initial begin
        cnt_out  = 0;
        tick_err = 0;
        host_en  = 1'b0;
        repeat (4) @(negedge clk);
        check("R1 reset wgate", int'(wgate), 0);
        check("R1 reset drq", int'(drq), 0);
        check("R1 reset lost_data", int'(lost_data), 0);
        check("R1 reset done", int'(done), 0);
        check("R1 reset wr_valid", int'(wr_valid), 0);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);

        for (int v = 0; v < NV; v++) begin
            run_vec(v);
            repeat (20) @(negedge clk);
        end

        check("R11 bytes only after tick", tick_err, 0);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule